// File: doc/BRIEF.md
# PCI Target Address Claim Logic

This block sits on the target side of a PCI-style shared bus and decides, for every transaction, whether the local agent answers. In the address phase it looks at the command code, the full address/data word and the per-slot IDSEL line. It then claims the transaction as a configuration access or as an I/O access, or lets it pass. The response side drives DEVSEL, TRDY and STOP with a fixed timing. DEVSEL rises one cycle after the address phase. The data response or a target-abort follows one cycle later, after the byte enables of the first data phase have been checked against the I/O window.

A configuration access reports a dword register index taken from the address. An I/O access is checked against a window of 2^IO_WIN_LOG2 bytes aligned on IO_BASE. When an enabled byte lane falls outside that window, the access is target-aborted and no data moves. Memory commands are decoded only far enough to be refused. All bus signals are treated as active-high, so the block sits behind the pad inverters. The block drives no data of its own.

Top module: `pci_tgt_claim`

## Requirements
- R1: While rst is high, and in the cycle after it falls, devsel, trdy, stop and xfer are 0, and space reads 2'b00 (none).
- R2: A transaction is claimed as configuration (space = 2'b01) only when the address-phase command is 4'hA or 4'hB, idsel is 1 and ad[1:0] is 2'b00; with any other combination a configuration command is not claimed.
- R3: For a claimed configuration access, reg_idx equals ad[7:2] of the address phase and stays constant until the transaction ends.
- R4: A transaction with command 4'h2 or 4'h3 is claimed as I/O (space = 2'b10) exactly when the 32-bit byte address on ad lies in [IO_BASE, IO_BASE + 2^IO_WIN_LOG2).
- R5: For a claimed I/O access, cbe[k] = 1 in the first data-phase cycle enables byte lane k at address {ad[31:2], k}. If any enabled lane lies outside the window, the block target-aborts: stop = 1, devsel = 0, trdy = 0, and xfer stays 0.
- R6: Memory commands (4'h6, 4'h7) and every other command code outside 4'h2, 4'h3, 4'hA and 4'hB are never claimed: devsel, trdy and stop stay 0.
- R7: For a claimed transaction, devsel is 1 in the cycle after the address phase, with trdy and stop both 0. In the following cycle the response appears: either trdy = 1 with devsel = 1, or the abort pattern of R5.
- R8: Once trdy or stop is 1, devsel, trdy and stop keep their values until a cycle with irdy = 1 and frame = 0 completes the last data phase.
- R9: After a transaction, a new address phase is recognised only after one cycle in which frame and irdy are both 0. A frame that rises without such a cycle is not claimed.
- R10: xfer is 1 exactly in cycles where irdy and trdy are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame | input | 1 | Initiator transaction framing, active high |
| irdy | input | 1 | Initiator ready, active high |
| idsel | input | 1 | Configuration select for this slot |
| ad | input | 32 | Address/data lines (address used in address phase) |
| cbe | input | 4 | Command in address phase, byte enables in data phase (1 = enabled) |
| devsel | output | 1 | Target claims the transaction |
| trdy | output | 1 | Target ready |
| stop | output | 1 | Target requests termination (abort when devsel is 0) |
| xfer | output | 1 | A data word moves this cycle |
| space | output | 2 | Claimed space: 00 none, 01 configuration, 10 I/O |
| reg_idx | output | 6 | Dword register index of a configuration access |

## Verification
The bench runs every command code with both IDSEL values and all four low address bit patterns. A decoder that drops the IDSEL term or the ad[1:0] term would claim cycles that belong to other slots. The I/O part crosses byte addresses just below, inside and just above a two-byte window with all sixteen byte-enable patterns. An off-by-one window bound or a lane check that ignores ad[31:2] would then move data from a byte outside the window, or abort a legal access. Wait-state runs hold irdy low after trdy or stop. A response that drops early would lose the data phase. A frame raised with no idle cycle checks that the block does not latch a transaction in mid-stream.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned LANES   = 4;
    localparam int unsigned LANE_W  = $clog2(LANES);
    localparam int unsigned IDX_W   = 6;
    localparam int unsigned DWORD_W = ADDR_W - LANE_W;

    localparam logic [3:0] CMD_IO_RD  = 4'h2;
    localparam logic [3:0] CMD_IO_WR  = 4'h3;
    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    typedef enum logic [1:0] {
        SPACE_NONE = 2'b00,
        SPACE_CFG  = 2'b01,
        SPACE_IO   = 2'b10
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLAIM,
        ST_DATA,
        ST_ABORT,
        ST_DRAIN
    } tstate_e;

    typedef struct packed {
        space_e               space;
        logic [IDX_W-1:0]     reg_idx;
        logic [DWORD_W-1:0]   dword;
    } claim_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned       lg2);
        return (a >> lg2) == (base >> lg2);
    endfunction

    function automatic logic is_io_cmd(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR);
    endfunction

    function automatic logic is_cfg_cmd(input logic [3:0] c);
        return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
    endfunction

    function automatic logic is_mem_cmd(input logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'h0000_0400,
    parameter int unsigned       IO_WIN_LOG2 = 4
) (
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] ad,
    input  logic              idsel,
    output claim_t            dec
);

    logic cfg_hit;
    logic io_hit;
    logic mem_seen;

    always_comb begin
        cfg_hit  = is_cfg_cmd(cmd) && idsel && (ad[LANE_W-1:0] == '0);
        io_hit   = is_io_cmd(cmd) && in_window(ad, IO_BASE, IO_WIN_LOG2);
        // memory space is recognised but never answered
        mem_seen = is_mem_cmd(cmd);

        dec         = '0;
        dec.dword   = ad[ADDR_W-1:LANE_W];
        dec.reg_idx = ad[IDX_W+LANE_W-1:LANE_W];
        if (cfg_hit) begin
            dec.space = SPACE_CFG;
        end else if (io_hit && !mem_seen) begin
            dec.space = SPACE_IO;
        end else begin
            dec.space = SPACE_NONE;
        end
    end

endmodule

// File: rtl/pci_tgt_lanechk.sv
module pci_tgt_lanechk
    import pci_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'h0000_0400,
    parameter int unsigned       IO_WIN_LOG2 = 4
) (
    input  logic [DWORD_W-1:0] dword,
    input  logic [LANES-1:0]   be,
    output logic               all_in
);

    logic [LANES-1:0] lane_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [LANE_W-1:0] LANE = LANE_W'(k);
        logic [ADDR_W-1:0] lane_addr;
        always_comb begin
            lane_addr  = {dword, LANE};
            lane_ok[k] = !be[k] || in_window(lane_addr, IO_BASE, IO_WIN_LOG2);
        end
    end

    assign all_in = &lane_ok;

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame,
    input  logic   irdy,
    input  claim_t dec,
    input  logic   lanes_ok,
    output claim_t held,
    output logic   devsel,
    output logic   trdy,
    output logic   stop
);

    tstate_e st_q, st_d;
    claim_t  held_q;
    logic    last_phase_done;

    assign last_phase_done = irdy && !frame;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (frame) begin
                    st_d = (dec.space != SPACE_NONE) ? ST_CLAIM : ST_DRAIN;
                end else if (irdy) begin
                    st_d = ST_DRAIN;
                end
            end
            ST_CLAIM: begin
                if (held_q.space == SPACE_CFG) begin
                    st_d = ST_DATA;
                end else begin
                    st_d = lanes_ok ? ST_DATA : ST_ABORT;
                end
            end
            ST_DATA: begin
                if (last_phase_done) st_d = ST_DRAIN;
            end
            ST_ABORT: begin
                if (last_phase_done) st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!frame && !irdy) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            held_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && frame) begin
                held_q <= dec;
            end else if (st_d == ST_IDLE) begin
                held_q.space <= SPACE_NONE;
            end
        end
    end

    always_comb begin
        devsel = (st_q == ST_CLAIM) || (st_q == ST_DATA);
        trdy   = (st_q == ST_DATA);
        stop   = (st_q == ST_ABORT);
    end

    assign held = held_q;

endmodule

// File: rtl/pci_tgt_claim.sv
module pci_tgt_claim
    import pci_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'h0000_0400,
    parameter int unsigned       IO_WIN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame,
    input  logic              irdy,
    input  logic              idsel,
    input  logic [ADDR_W-1:0] ad,
    input  logic [LANES-1:0]  cbe,
    output logic              devsel,
    output logic              trdy,
    output logic              stop,
    output logic              xfer,
    output logic [1:0]        space,
    output logic [IDX_W-1:0]  reg_idx
);

    claim_t dec;
    claim_t held;
    logic   lanes_ok;

    pci_tgt_decode #(
        .IO_BASE     (IO_BASE),
        .IO_WIN_LOG2 (IO_WIN_LOG2)
    ) u_decode (
        .cmd   (cbe),
        .ad    (ad),
        .idsel (idsel),
        .dec   (dec)
    );

    pci_tgt_lanechk #(
        .IO_BASE     (IO_BASE),
        .IO_WIN_LOG2 (IO_WIN_LOG2)
    ) u_lanechk (
        .dword  (held.dword),
        .be     (cbe),
        .all_in (lanes_ok)
    );

    pci_tgt_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .frame    (frame),
        .irdy     (irdy),
        .dec      (dec),
        .lanes_ok (lanes_ok),
        .held     (held),
        .devsel   (devsel),
        .trdy     (trdy),
        .stop     (stop)
    );

    assign xfer    = trdy && irdy;
    assign space   = held.space;
    assign reg_idx = held.reg_idx;

endmodule

// File: rtl/pci_tgt_claim_chk.sv
module pci_tgt_claim_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame,
    input logic       irdy,
    input logic       idsel,
    input logic [1:0] ad_lo,
    input logic       devsel,
    input logic       trdy,
    input logic       stop,
    input logic       xfer,
    input logic [1:0] space
);

    AST_TRDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (trdy && !irdy) |=> (trdy && devsel)) else $error("trdy dropped early"); // R8

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stop && !irdy) |=> (stop && !devsel)) else $error("stop dropped early"); // R8

    AST_ABORT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        stop |-> (!devsel && !trdy && !xfer)) else $error("bad abort shape"); // R5

    AST_TRDY_WITH_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        $rose(trdy) |-> ($past(devsel) && devsel)) else $error("trdy without devsel"); // R7

    AST_DEVSEL_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel) |-> ($past(frame) && !trdy && !stop)) else $error("devsel timing"); // R7

    AST_CFG_SELECT: assert property (@(posedge clk) disable iff (rst)
        ($rose(devsel) && space == 2'b01) |-> ($past(idsel) && $past(ad_lo) == 2'b00))
        else $error("config claim without select"); // R2

    AST_XFER_MATCH: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (trdy && irdy)) else $error("xfer without handshake"); // R10

endmodule

bind pci_tgt_claim pci_tgt_claim_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .frame  (frame),
    .irdy   (irdy),
    .idsel  (idsel),
    .ad_lo  (ad[1:0]),
    .devsel (devsel),
    .trdy   (trdy),
    .stop   (stop),
    .xfer   (xfer),
    .space  (space)
);

// File: tb/tb_pci_tgt_claim.sv
module tb_pci_tgt_claim;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] WIN_BASE   = 32'h0000_1002;
    localparam int unsigned WIN_LG2    = 1;
    localparam int          WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame = 1'b0;
    logic        irdy = 1'b0;
    logic        idsel = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        devsel, trdy, stop, xfer;
    logic [1:0]  space;
    logic [5:0]  reg_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    pci_tgt_claim #(
        .IO_BASE     (WIN_BASE),
        .IO_WIN_LOG2 (WIN_LG2)
    ) dut (
        .clk     (clk),
        .rst     (rst),
        .frame   (frame),
        .irdy    (irdy),
        .idsel   (idsel),
        .ad      (ad),
        .cbe     (cbe),
        .devsel  (devsel),
        .trdy    (trdy),
        .stop    (stop),
        .xfer    (xfer),
        .space   (space),
        .reg_idx (reg_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic e_dev, input logic e_trdy,
                           input logic e_stop, input logic e_xfer);
        chk({devsel, trdy, stop, xfer} == {e_dev, e_trdy, e_stop, e_xfer}, req,
            "devsel/trdy/stop/xfer", {28'h0, devsel, trdy, stop, xfer},
            {28'h0, e_dev, e_trdy, e_stop, e_xfer});
    endtask

    function automatic bit win_has(input logic [31:0] a);
        return (a >= WIN_BASE) && (a < WIN_BASE + (32'd1 << WIN_LG2));
    endfunction

    // one address phase, one data phase, then an idle cycle
    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr,
                       input logic sel, input logic [3:0] be);
        bit is_cfg, is_io, abort_x, claimed;
        logic [1:0] e_space;
        is_cfg  = (cmd == 4'hA || cmd == 4'hB) && sel && (addr[1:0] == 2'b00);
        is_io   = (cmd == 4'h2 || cmd == 4'h3) && win_has(addr);
        claimed = is_cfg || is_io;
        abort_x = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (is_io && be[k] && !win_has({addr[31:2], 2'(k)})) abort_x = 1'b1;
        end
        e_space = is_cfg ? 2'b01 : (is_io ? 2'b10 : 2'b00);

        @(negedge clk);
        frame = 1'b1; irdy = 1'b0; ad = addr; cbe = cmd; idsel = sel;
        @(negedge clk);
        chk_out(is_cfg ? "R2" : (is_io ? "R4" : "R6"), claimed, 1'b0, 1'b0, 1'b0);
        chk(space == e_space, "R7", "space", {30'h0, space}, {30'h0, e_space});
        if (is_cfg) chk(reg_idx == addr[7:2], "R3", "reg_idx",
                        {26'h0, reg_idx}, {26'h0, addr[7:2]});
        frame = 1'b0; irdy = 1'b1; ad = '0; cbe = be; idsel = 1'b0;
        @(negedge clk);
        if (abort_x)      chk_out("R5", 1'b0, 1'b0, 1'b1, 1'b0);
        else if (claimed) chk_out("R10", 1'b1, 1'b1, 1'b0, 1'b1);
        else              chk_out("R6", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk_out("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        irdy = 1'b0;
    endtask

    // response held with irdy low for several cycles
    task automatic hold_run(input logic [3:0] cmd, input logic [31:0] addr,
                            input logic sel, input logic [3:0] be, input bit is_abort);
        @(negedge clk);
        frame = 1'b1; irdy = 1'b0; ad = addr; cbe = cmd; idsel = sel;
        @(negedge clk);
        cbe = be; ad = '0; idsel = 1'b0;
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            if (is_abort) chk_out("R8", 1'b0, 1'b0, 1'b1, 1'b0);
            else          chk_out("R8", 1'b1, 1'b1, 1'b0, 1'b0);
        end
        frame = 1'b0; irdy = 1'b1;
        #1;
        chk(xfer == !is_abort, "R10", "xfer on completion", {31'h0, xfer}, {31'h0, !is_abort});
        @(negedge clk);
        chk_out("R8", 1'b0, 1'b0, 1'b0, 1'b0);
        irdy = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        chk(space == 2'b00, "R1", "space in reset", {30'h0, space}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);

        // every command, both select values, every low address pattern
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    txn(4'(c), 32'h0000_1A40 | 32'(lo), 1'(s), 4'hF);
                end
            end
        end

        // configuration index sweep R3
        for (int i = 0; i < 64; i += 7) begin
            txn(4'hB, 32'h00AB_0000 | 32'(i << 2), 1'b1, 4'hF);
        end

        // I/O window edges and all byte enable patterns R4 R5
        for (int c = 0; c < 4; c++) begin
            logic [3:0] cm;
            cm = (c == 0) ? 4'h2 : (c == 1) ? 4'h3 : (c == 2) ? 4'h6 : 4'h7;
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 16; b++) begin
                    txn(cm, 32'h0000_1000 + 32'(a), 1'b0, 4'(b));
                end
            end
        end

        // wait states after trdy and after stop R8
        hold_run(4'hA, 32'h0000_0010, 1'b1, 4'hF, 1'b0);
        hold_run(4'h3, 32'h0000_1003, 1'b0, 4'b1000, 1'b0);
        hold_run(4'h2, 32'h0000_1002, 1'b0, 4'b0001, 1'b1);

        // frame raised with no idle cycle in between R9
        @(negedge clk);
        frame = 1'b1; irdy = 1'b0; ad = 32'h0000_2000; cbe = 4'h6; idsel = 1'b0;
        @(negedge clk);
        frame = 1'b0; irdy = 1'b1; cbe = 4'hF;
        @(negedge clk);
        frame = 1'b1; irdy = 1'b0; ad = 32'h0000_0004; cbe = 4'hA; idsel = 1'b1;
        @(negedge clk);
        chk_out("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        frame = 1'b0; irdy = 1'b1; idsel = 1'b0; cbe = 4'hF;
        @(negedge clk);
        chk_out("R9", 1'b0, 1'b0, 1'b0, 1'b0);
        irdy = 1'b0;
        // after a proper idle cycle the same access is claimed
        txn(4'hA, 32'h0000_0004, 1'b1, 4'hF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule